// File: doc/BRIEF.md
# Scrambled-Address Memory Test Sequencer

This block generates memory test traffic on the fly, without stored vectors. It walks the cells of a memory in physical coordinates. x is the column and moves fastest, y is the row, and the linear physical index is k = {y, x}. Each coordinate pair is converted to the device address that must be driven on the memory pins. The conversion is a conditional-inversion scramble, so the physical view keeps x increasing to the right and y increasing downward in every block.

Three algorithms are available:
- **Solid:** writes an address-derived word to every cell, then reads every cell back.
- **Checkerboard:** writes and reads a word set by the parity of x and y.
- **March:** runs four elements of read-expect and write operations, in ascending and descending physical order.

Read data is compared one cycle after each read. The first failing cell is recorded and the run continues to the end.

A pulse on `start` latches the algorithm and begins at physical cell (0, 0). `done` reports that the last comparison has been made. With the default parameters the device address is 17 bits wide: 9 row bits and 8 column bits.

Top module: `mtpg_top`

## Requirements
- R1: After reset, `busy`, `done`, `fail`, `mem_we` and `mem_re` are 0, and `fail_addr`, `fail_x` and `fail_y` are 0.
- R2: Let AW = XW + YW. The device address is {ya[YW-1], xa[XW-1], xa[XW-2:0], ya[YW-2:0]}. In it, ya[YW-1] = y[YW-1], ya[YW-2:0] = y[YW-2:0] XOR all-copies-of y[YW-1], xa[XW-1] = x[XW-1], and xa[XW-2:0] = x[XW-2:0] XOR all-copies-of NOT x[XW-1].
- R3: Solid (alg 0) writes every cell in ascending k, then reads every cell in ascending k. It issues one operation per cycle, starting in the cycle after the start edge, and never raises `mem_we` and `mem_re` together.
- R4: The solid data word has bit i = k[i] for i < DW-1, and its MSB is k[AW-1]. The same word is the expected read value.
- R5: Checkerboard (alg 1) follows the same write pass and read pass as solid, with every data bit equal to x[0] XOR y[0].
- R6: March (alg 2) runs four elements:
  - ascending: write 0;
  - ascending: read 0, then write 1 on the same cell;
  - descending k: read 1, then write 0;
  - descending k: read 0.

  Here 0 and 1 mean all-zero and all-ones words.
- R7: `mem_rdata` is compared in the cycle after `mem_re` with the expected word, and a mismatch sets `fail`.
- R8: Only the first mismatch of a run updates `fail_addr`, `fail_x` and `fail_y`. Later mismatches leave them unchanged, and the run continues.
- R9: `done` goes to 1 in the second cycle after the last operation is issued, and stays 1 until the next start. No operation is issued in between.
- R10: `start` restarts from k = 0 at any time, also mid-run, and clears `done`, `fail` and the capture registers.
- R11: `alg` is sampled only on the start cycle. Value 3 runs march, and changing `alg` during a run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (also restarts) |
| alg | input | 2 | Algorithm: 0 solid, 1 checkerboard, 2 or 3 march |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_addr | output | XW+YW | Scrambled device address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid one cycle after `mem_re` |
| busy | output | 1 | Operations are being issued |
| done | output | 1 | Run complete |
| fail | output | 1 | At least one read mismatch |
| fail_addr | output | XW+YW | Device address of first mismatch |
| fail_x | output | XW | Physical column of first mismatch |
| fail_y | output | YW | Physical row of first mismatch |

## Verification
The bench builds the block with XW = 3, YW = 3 and DW = 4, which gives a 64-cell memory. At this size every operation of every algorithm can be checked against an arithmetic model, including:
- both mirror polarities of the scramble in rows and columns;
- the solid MSB flip at the half point;
- the descending march elements.

A bench memory with injectable stuck bits then shows which of two faulty cells is captured first, in ascending and in descending order.

// File: rtl/mtpg_pkg.sv
package mtpg_pkg;

    typedef enum logic [1:0] {
        ALG_SOLID   = 2'd0,
        ALG_CHECKER = 2'd1,
        ALG_MARCH   = 2'd2,
        ALG_MARCH_B = 2'd3
    } alg_e;

    // One cell operation: read-expect or write, with data inversion flag
    typedef struct packed {
        logic rd;
        logic inv;
    } op_t;

    // One test element: direction, number of ops per cell, the ops
    typedef struct packed {
        logic desc;
        logic two;
        op_t  op0;
        op_t  op1;
    } elem_t;

    function automatic logic is_two_pass(alg_e a);
        return (a == ALG_SOLID) || (a == ALG_CHECKER);
    endfunction

    function automatic elem_t elem_of(alg_e a, logic [1:0] e);
        elem_t r;
        r = '0;
        if (is_two_pass(a)) begin
            r.op0.rd = (e != 2'd0);
        end else begin
            case (e)
                2'd0: begin
                    r.op0 = '{rd: 1'b0, inv: 1'b0};
                end
                2'd1: begin
                    r.two = 1'b1;
                    r.op0 = '{rd: 1'b1, inv: 1'b0};
                    r.op1 = '{rd: 1'b0, inv: 1'b1};
                end
                2'd2: begin
                    r.desc = 1'b1;
                    r.two  = 1'b1;
                    r.op0  = '{rd: 1'b1, inv: 1'b1};
                    r.op1  = '{rd: 1'b0, inv: 1'b0};
                end
                default: begin
                    r.desc = 1'b1;
                    r.op0  = '{rd: 1'b1, inv: 1'b0};
                end
            endcase
        end
        return r;
    endfunction

    function automatic logic [1:0] last_elem(alg_e a);
        return is_two_pass(a) ? 2'd1 : 2'd3;
    endfunction

endpackage

// File: rtl/mtpg_scramble.sv
module mtpg_scramble #(
    parameter int XW = 8,
    parameter int YW = 9,
    localparam int AW = XW + YW
) (
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    output logic [AW-1:0] addr
);
    logic [XW-1:0] xa;
    logic [YW-1:0] ya;

    // Row: mirror low bits when the row block bit is set
    assign ya[YW-1]   = y[YW-1];
    assign ya[YW-2:0] = y[YW-2:0] ^ {(YW-1){y[YW-1]}};
    // Column: mirror low bits when the column block bit is clear
    assign xa[XW-1]   = x[XW-1];
    assign xa[XW-2:0] = x[XW-2:0] ^ {(XW-1){~x[XW-1]}};

    assign addr = {ya[YW-1], xa[XW-1], xa[XW-2:0], ya[YW-2:0]};
endmodule

// File: rtl/mtpg_seq.sv
module mtpg_seq
    import mtpg_pkg::*;
#(
    parameter int XW = 8,
    parameter int YW = 9,
    localparam int AW = XW + YW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [1:0]    alg,
    output logic          active,
    output alg_e          alg_q,
    output op_t           op,
    output logic [XW-1:0] cur_x,
    output logic [YW-1:0] cur_y,
    output logic          last_op
);
    logic          run_q;
    logic [1:0]    elem_q;
    logic [AW-1:0] cnt_q;
    logic          step_q;

    elem_t         elem;
    logic [AW-1:0] phys;
    logic          last_step;
    logic          last_cell;
    logic          last_el;

    always_comb begin
        elem      = elem_of(alg_q, elem_q);
        phys      = elem.desc ? ~cnt_q : cnt_q;
        op        = step_q ? elem.op1 : elem.op0;
        last_step = !elem.two || step_q;
        last_cell = &cnt_q;
        last_el   = (elem_q == last_elem(alg_q));
    end

    assign active  = run_q;
    assign cur_x   = phys[XW-1:0];
    assign cur_y   = phys[AW-1:XW];
    assign last_op = run_q && last_step && last_cell && last_el;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            alg_q  <= ALG_SOLID;
            elem_q <= '0;
            cnt_q  <= '0;
            step_q <= 1'b0;
        end else if (start) begin
            run_q  <= 1'b1;
            alg_q  <= alg_e'(alg);
            elem_q <= '0;
            cnt_q  <= '0;
            step_q <= 1'b0;
        end else if (run_q) begin
            if (!last_step) begin
                step_q <= 1'b1;
            end else begin
                step_q <= 1'b0;
                cnt_q  <= cnt_q + 1'b1;
                if (last_cell) begin
                    if (last_el) run_q  <= 1'b0;
                    else         elem_q <= elem_q + 2'd1;
                end
            end
        end
    end
endmodule

// File: rtl/mtpg_datagen.sv
module mtpg_datagen
    import mtpg_pkg::*;
#(
    parameter int XW = 8,
    parameter int YW = 9,
    parameter int DW = 8,
    localparam int AW = XW + YW
) (
    input  alg_e          alg,
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    input  logic          inv,
    output logic [DW-1:0] data
);
    logic [AW-1:0] k;
    logic [DW-1:0] base;

    assign k = {y, x};

    always_comb begin
        case (alg)
            ALG_SOLID:   base = {k[AW-1], k[DW-2:0]};
            ALG_CHECKER: base = {DW{x[0] ^ y[0]}};
            default:     base = '0;
        endcase
        data = base ^ {DW{inv}};
    end
endmodule

// File: rtl/mtpg_cmp.sv
module mtpg_cmp #(
    parameter int XW = 8,
    parameter int YW = 9,
    parameter int DW = 8,
    localparam int AW = XW + YW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          issue_rd,
    input  logic [DW-1:0] exp_data,
    input  logic [AW-1:0] addr,
    input  logic [XW-1:0] x,
    input  logic [YW-1:0] y,
    input  logic          last_op,
    input  logic [DW-1:0] rdata,
    output logic          done,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic [XW-1:0] fail_x,
    output logic [YW-1:0] fail_y
);
    logic          pend_q;
    logic          last_q;
    logic [DW-1:0] exp_q;
    logic [AW-1:0] addr_q;
    logic [XW-1:0] x_q;
    logic [YW-1:0] y_q;
    logic          miss;

    assign miss = pend_q && (rdata != exp_q);

    always_ff @(posedge clk) begin
        if (rst || start) begin
            pend_q    <= 1'b0;
            last_q    <= 1'b0;
            exp_q     <= '0;
            addr_q    <= '0;
            x_q       <= '0;
            y_q       <= '0;
            done      <= 1'b0;
            fail      <= 1'b0;
            fail_addr <= '0;
            fail_x    <= '0;
            fail_y    <= '0;
        end else begin
            pend_q <= issue_rd;
            last_q <= last_op;
            exp_q  <= exp_data;
            addr_q <= addr;
            x_q    <= x;
            y_q    <= y;
            if (miss && !fail) begin
                fail      <= 1'b1;
                fail_addr <= addr_q;
                fail_x    <= x_q;
                fail_y    <= y_q;
            end
            if (last_q) done <= 1'b1;
        end
    end
endmodule

// File: rtl/mtpg_top.sv
module mtpg_top
    import mtpg_pkg::*;
#(
    parameter int XW = 8,
    parameter int YW = 9,
    parameter int DW = 8,
    localparam int AW = XW + YW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [1:0]    alg,
    output logic          mem_we,
    output logic          mem_re,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          busy,
    output logic          done,
    output logic          fail,
    output logic [AW-1:0] fail_addr,
    output logic [XW-1:0] fail_x,
    output logic [YW-1:0] fail_y
);
    logic          active;
    alg_e          alg_q;
    op_t           op;
    logic [XW-1:0] cur_x;
    logic [YW-1:0] cur_y;
    logic          last_op;
    logic [DW-1:0] word;

    mtpg_seq #(.XW(XW), .YW(YW)) seq_i (
        .clk(clk), .rst(rst), .start(start), .alg(alg),
        .active(active), .alg_q(alg_q), .op(op),
        .cur_x(cur_x), .cur_y(cur_y), .last_op(last_op)
    );

    mtpg_scramble #(.XW(XW), .YW(YW)) scr_i (
        .x(cur_x), .y(cur_y), .addr(mem_addr)
    );

    mtpg_datagen #(.XW(XW), .YW(YW), .DW(DW)) dgen_i (
        .alg(alg_q), .x(cur_x), .y(cur_y), .inv(op.inv), .data(word)
    );

    assign mem_we    = active && !op.rd;
    assign mem_re    = active && op.rd;
    assign mem_wdata = word;
    assign busy      = active;

    mtpg_cmp #(.XW(XW), .YW(YW), .DW(DW)) cmp_i (
        .clk(clk), .rst(rst), .start(start),
        .issue_rd(mem_re), .exp_data(word), .addr(mem_addr),
        .x(cur_x), .y(cur_y), .last_op(last_op), .rdata(mem_rdata),
        .done(done), .fail(fail), .fail_addr(fail_addr),
        .fail_x(fail_x), .fail_y(fail_y)
    );
endmodule

// File: rtl/mtpg_chk.sv
module mtpg_chk #(
    parameter int XW = 8,
    parameter int YW = 9,
    localparam int AW = XW + YW
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          mem_we,
    input logic          mem_re,
    input logic [AW-1:0] mem_addr,
    input logic          done,
    input logic          fail,
    input logic [AW-1:0] fail_addr,
    input logic [XW-1:0] cur_x,
    input logic [YW-1:0] cur_y
);
    AST_ONE_OP: assert property (@(posedge clk) disable iff (rst) !(mem_we && mem_re)); // R3
    AST_BLOCK_BITS: assert property (@(posedge clk) disable iff (rst) (mem_we || mem_re) |-> (mem_addr[AW-1] == cur_y[YW-1] && mem_addr[AW-2] == cur_x[XW-1])); // R2
    AST_ROW_MIRROR: assert property (@(posedge clk) disable iff (rst) (mem_we || mem_re) |-> ($countones(mem_addr[YW-2:0] ^ cur_y[YW-2:0]) == (cur_y[YW-1] ? YW-1 : 0))); // R2
    AST_COL_MIRROR: assert property (@(posedge clk) disable iff (rst) (mem_we || mem_re) |-> ($countones(mem_addr[AW-3:YW-1] ^ cur_x[XW-2:0]) == (cur_x[XW-1] ? 0 : XW-1))); // R2
    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst) done |-> (!mem_we && !mem_re)); // R9
    AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (rst) (fail && !start) |=> fail); // R8
    AST_CAPT_HOLD: assert property (@(posedge clk) disable iff (rst) (fail && !start) |=> $stable(fail_addr)); // R8
    AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst) start |=> (!done && !fail)); // R10
endmodule

bind mtpg_top mtpg_chk #(.XW(XW), .YW(YW)) chk_i (
    .clk(clk), .rst(rst), .start(start), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .done(done), .fail(fail), .fail_addr(fail_addr),
    .cur_x(cur_x), .cur_y(cur_y)
);

// File: tb/mtpg_top_tb_top.sv
module mtpg_top_tb_top;
    localparam int XW = 3;
    localparam int YW = 3;
    localparam int DW = 4;
    localparam int AW = XW + YW;
    localparam int NC = 1 << AW;
    localparam int ONES = (1 << DW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [1:0]    alg = 2'd0;
    logic          mem_we, mem_re, busy, done, fail;
    logic [AW-1:0] mem_addr, fail_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic [XW-1:0] fail_x;
    logic [YW-1:0] fail_y;

    int n_tests = 0;
    int n_fail  = 0;

    // stuck-bit fault slots on the read path of the bench memory
    bit f_en [2];
    int f_addr [2];
    int f_bit [2];
    bit f_val [2];

    logic [DW-1:0] mem [NC];

    always #5 clk = ~clk;

    mtpg_top #(.XW(XW), .YW(YW), .DW(DW)) dut_i (
        .clk(clk), .rst(rst), .start(start), .alg(alg),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy),
        .done(done), .fail(fail), .fail_addr(fail_addr),
        .fail_x(fail_x), .fail_y(fail_y)
    );

    function automatic int faulty(int addr, int v);
        int r;
        r = v;
        for (int i = 0; i < 2; i++)
            if (f_en[i] && f_addr[i] == addr)
                r = f_val[i] ? (r | (1 << f_bit[i])) : (r & ~(1 << f_bit[i]));
        return r;
    endfunction

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= DW'(faulty(int'(mem_addr), int'(mem[mem_addr])));
    end

    function automatic int dev_addr(int x, int y);
        int xh, yh, xl, yl;
        xh = (x >> (XW-1)) & 1;
        yh = (y >> (YW-1)) & 1;
        xl = (x & ((1 << (XW-1)) - 1)) ^ (xh ? 0 : ((1 << (XW-1)) - 1));
        yl = (y & ((1 << (YW-1)) - 1)) ^ (yh ? ((1 << (YW-1)) - 1) : 0);
        return (yh << (AW-1)) | (xh << (AW-2)) | (xl << (YW-1)) | yl;
    endfunction

    function automatic int solid_word(int k);
        return (((k >> (AW-1)) & 1) << (DW-1)) | (k & ((1 << (DW-1)) - 1));
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_alg(input logic [1:0] a, input string req);
        int  errs;
        bit  efail;
        int  efa, efx, efy;
        bit  march;
        errs = 0; efail = 0; efa = 0; efx = 0; efy = 0;
        march = (a >= 2);
        @(negedge clk); start = 1'b1; alg = a;
        @(negedge clk); start = 1'b0; alg = ~a;   // R11: changed mid-run
        chk(done == 1'b0 && fail == 1'b0 && busy == 1'b1, "R10", "flags after start",
            {busy, done, fail}, 4);
        for (int e = 0; e < (march ? 4 : 2); e++) begin
            for (int c = 0; c < NC; c++) begin
                int k, x, y, nops;
                k = (march && e >= 2) ? NC - 1 - c : c;
                x = k & ((1 << XW) - 1);
                y = k >> XW;
                nops = (march && (e == 1 || e == 2)) ? 2 : 1;
                for (int s = 0; s < nops; s++) begin
                    bit rd;
                    int val, addr;
                    if (!march) begin
                        rd  = (e == 1);
                        val = (a == 0) ? solid_word(k) : (((x ^ y) & 1) ? ONES : 0);
                    end else begin
                        case (e)
                            0: begin rd = 0; val = 0; end
                            1: begin rd = (s == 0); val = (s == 0) ? 0 : ONES; end
                            2: begin rd = (s == 0); val = (s == 0) ? ONES : 0; end
                            default: begin rd = 1; val = 0; end
                        endcase
                    end
                    addr = dev_addr(x, y);
                    if (mem_we !== !rd || mem_re !== rd || int'(mem_addr) != addr ||
                        (!rd && int'(mem_wdata) != val)) begin
                        errs++;
                        if (errs == 1)
                            $display("op mismatch e=%0d k=%0d s=%0d we=%b re=%b addr=%0d/%0d data=%0d/%0d",
                                     e, k, s, mem_we, mem_re, mem_addr, addr, mem_wdata, val);
                    end
                    if (rd && !efail && faulty(addr, val) != val) begin
                        efail = 1; efa = addr; efx = x; efy = y;
                    end
                    @(negedge clk);
                end
            end
        end
        chk(errs == 0, req, "operation stream", errs, 0);
        chk(done == 1'b0 && !mem_we && !mem_re, "R9", "quiet cycle before done", done, 0);
        @(negedge clk);
        chk(done == 1'b1 && busy == 1'b0, "R9", "done two cycles after last op", done, 1);
        chk(fail == efail, "R7", "fail flag", fail, efail);
        if (efail) begin
            chk(int'(fail_addr) == efa, "R8", "first fail address", fail_addr, efa);
            chk(int'(fail_x) == efx, "R8", "first fail x", fail_x, efx);
            chk(int'(fail_y) == efy, "R8", "first fail y", fail_y, efy);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 2; i++) begin
            f_en[i] = 0; f_addr[i] = 0; f_bit[i] = 0; f_val[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !fail && !mem_we && !mem_re, "R1", "idle after reset",
            {busy, done, fail, mem_we, mem_re}, 0);
        chk(fail_addr == '0 && fail_x == '0 && fail_y == '0, "R1", "capture zero",
            fail_addr, 0);

        // first solid op: x=0,y=0 -> column mirrored -> address 12
        @(negedge clk); start = 1'b1; alg = 2'd0;
        @(negedge clk); start = 1'b0;
        chk(mem_we && int'(mem_addr) == 12, "R2", "first device address", mem_addr, 12);
        repeat (10) @(negedge clk);
        // mid-run restart into checkerboard
        run_alg(2'd1, "R10 R5");

        run_alg(2'd0, "R3 R4");
        run_alg(2'd2, "R6 R11");
        run_alg(2'd3, "R6 R11");

        // solid with two stuck-at-1 cells: k=9 bit3, k=40 bit1
        f_en[0] = 1; f_addr[0] = dev_addr(1, 1); f_bit[0] = 3; f_val[0] = 1;
        f_en[1] = 1; f_addr[1] = dev_addr(0, 5); f_bit[1] = 1; f_val[1] = 1;
        run_alg(2'd0, "R3 R4 R7 R8");

        // march with two stuck-at-0 cells: descending read finds k=50 first
        f_en[0] = 1; f_addr[0] = dev_addr(5, 0); f_bit[0] = 0; f_val[0] = 0;
        f_en[1] = 1; f_addr[1] = dev_addr(2, 6); f_bit[1] = 2; f_val[1] = 0;
        run_alg(2'd2, "R6 R7 R8");

        // clean checkerboard: start must clear the earlier fail
        f_en[0] = 0; f_en[1] = 0;
        run_alg(2'd1, "R5 R10");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule